// File: doc/BRIEF.md
# Interrupt Gating Controller for a Serial Bus Peripheral

This block decides whether a serial bus peripheral raises its interrupt line. Event pulses from the protocol engine are captured in a sticky status bank. Software acknowledges an event by writing a one to its status bit. A separate mask bank can only be changed indirectly. A write to the disable strobe sets mask bits, and a write to the enable strobe clears them. The mask itself cannot be written. A registered, active-high interrupt is raised whenever a pending status bit is not masked.

Mask and status share one bit layout. Bit 0 is transfer done, bit 1 is more data wanted, bit 2 is a missing acknowledge, bit 3 is a transfer timeout and bit 4 is slave ready. Bit 5 is a receive overrun, bit 6 is a transmit FIFO overrun, bit 7 is a receive FIFO underrun and bit 9 is arbitration lost. Bit 8 and bits 15:10 are not implemented. The register bus supplies one shared write data word with four independent write strobes, plus a one-bit read select. A read select of 0 returns status and 1 returns mask.

Top module: `intr_gate_ctrl`

## Requirements
- R1: After reset the mask reads 0x02FF, the status reads 0x0000 and the interrupt output is 0.
- R2: When the disable strobe is high, every implemented mask bit whose write data bit is 1 becomes 1 at the next clock edge. Mask bits whose write data bit is 0 keep their value.
- R3: When the enable strobe is high, every implemented mask bit whose write data bit is 1 becomes 0 at the next clock edge. Mask bits whose write data bit is 0 keep their value.
- R4: When enable and disable strobes are high in the same cycle, a bit set in the write data ends up as 1 in the mask.
- R5: The mask-address write strobe has no effect on the mask, the status or the interrupt.
- R6: Bits 8 and 15:10 always read 0 in both mask and status, whatever is written or signalled on them.
- R7: A status bit set by an event stays set until it is cleared by a status write.
- R8: A status write clears each status bit whose write data bit is 1. If an event for the same bit arrives in that cycle, the bit stays set.
- R9: An event sets its status bit at the next clock edge, whether or not the bit is masked.
- R10: The interrupt output in cycle t+1 is 1 exactly when, in cycle t, some status bit was 1 while its mask bit was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 16 | One-cycle event pulses, one per status bit |
| wr_data_i | input | 16 | Write data shared by all write strobes |
| wr_enable_i | input | 1 | Write strobe: clear mask bits selected by write data |
| wr_disable_i | input | 1 | Write strobe: set mask bits selected by write data |
| wr_clear_i | input | 1 | Write strobe: clear status bits selected by write data |
| wr_mask_i | input | 1 | Write strobe to the read-only mask address (ignored) |
| rd_sel_i | input | 1 | Read select: 0 status, 1 mask |
| rd_data_o | output | 16 | Read data |
| irq_o | output | 1 | Registered active-high interrupt |

## Verification
Two collisions can occur in the same cycle. A status clear and an event can hit the same bit, and an enable and a disable can hit the same mask bit. The bench provokes both on every bit position in turn, then again inside a long pseudo-random stream. In each case the read-back values and the interrupt line are compared against a bench model in which the event beats the clear and the set beats the clear.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
   localparam int unsigned REG_W_DEFAULT = 16;
   localparam logic [15:0] IMPL_DEFAULT = 16'h02FF;

   typedef enum logic {
      RD_STATUS = 1'b0,
      RD_MASK   = 1'b1
   } rd_sel_e;
endpackage

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
   parameter int unsigned REG_W = 16,
   parameter logic [REG_W-1:0] IMPL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_stb,
   input  logic             dis_stb,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] mask_o
);
   for (genvar i = 0; i < REG_W; i++) begin : g_bit
      if (IMPL[i]) begin : g_impl
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  bit_q <= 1'b1;
            else if (dis_stb && wdata[i]) bit_q <= 1'b1;
            else if (en_stb && wdata[i])  bit_q <= 1'b0;
         end
         assign mask_o[i] = bit_q;
      end else begin : g_rsvd
         assign mask_o[i] = 1'b0;
      end
   end

   // disable sets, and wins over enable
   assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      dis_stb |=> ((mask_o & $past(wdata) & IMPL) == ($past(wdata) & IMPL)));
   assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (en_stb && !dis_stb) |=> ((mask_o & $past(wdata)) == '0));
   // R4: same-cycle collision keeps the bit set
   assert_collide_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (en_stb && dis_stb) |=> ((mask_o & $past(wdata & IMPL)) == $past(wdata & IMPL)));
   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_stb && !dis_stb) |=> $stable(mask_o));
   assert_rsvd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_o & ~IMPL) == '0);
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
   parameter int unsigned REG_W = 16,
   parameter logic [REG_W-1:0] IMPL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_stb,
   input  logic [REG_W-1:0] wdata,
   input  logic [REG_W-1:0] evt,
   output logic [REG_W-1:0] status_o
);
   for (genvar i = 0; i < REG_W; i++) begin : g_bit
      if (IMPL[i]) begin : g_impl
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  bit_q <= 1'b0;
            else if (evt[i])              bit_q <= 1'b1;
            else if (clr_stb && wdata[i]) bit_q <= 1'b0;
         end
         assign status_o[i] = bit_q;
      end else begin : g_rsvd
         assign status_o[i] = 1'b0;
      end
   end

   assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_stb |=> ((status_o & $past(status_o)) == $past(status_o)));
   assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr_stb |=> ((status_o & $past(wdata & ~evt)) == '0));
   // event beats a same-cycle clear (R8) and ignores the mask
   assert_evt_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status_o & $past(evt & IMPL)) == $past(evt & IMPL)));
   assert_rsvd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o & ~IMPL) == '0);
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
   parameter int unsigned REG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] status,
   input  logic [REG_W-1:0] mask,
   output logic             irq_o
);
   logic [REG_W-1:0] live;
   assign live = status & ~mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= |live;
   end

   assert_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past((status & ~mask) != '0));
   assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((status & ~mask) == '0) |=> !irq_o);
endmodule

// File: rtl/intr_gate_ctrl.sv
module intr_gate_ctrl #(
   parameter int unsigned REG_W = irq_gate_pkg::REG_W_DEFAULT,
   parameter logic [REG_W-1:0] IMPL_BITS = REG_W'(irq_gate_pkg::IMPL_DEFAULT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] evt_i,
   input  logic [REG_W-1:0] wr_data_i,
   input  logic             wr_enable_i,
   input  logic             wr_disable_i,
   input  logic             wr_clear_i,
   input  logic             wr_mask_i,
   input  logic             rd_sel_i,
   output logic [REG_W-1:0] rd_data_o,
   output logic             irq_o
);
   import irq_gate_pkg::*;

   if (REG_W < 1) begin : g_bad_width
      $error("REG_W must be at least 1");
   end
   if (IMPL_BITS == '0) begin : g_bad_impl
      $error("IMPL_BITS must select at least one bit");
   end

   logic [REG_W-1:0] mask_w;
   logic [REG_W-1:0] status_w;

   irq_mask_bank #(.REG_W(REG_W), .IMPL(IMPL_BITS)) u_mask (
      .clk(clk), .rst_n(rst_n),
      .en_stb(wr_enable_i), .dis_stb(wr_disable_i),
      .wdata(wr_data_i), .mask_o(mask_w)
   );

   irq_status_bank #(.REG_W(REG_W), .IMPL(IMPL_BITS)) u_status (
      .clk(clk), .rst_n(rst_n),
      .clr_stb(wr_clear_i), .wdata(wr_data_i),
      .evt(evt_i), .status_o(status_w)
   );

   irq_out_stage #(.REG_W(REG_W)) u_out (
      .clk(clk), .rst_n(rst_n),
      .status(status_w), .mask(mask_w), .irq_o(irq_o)
   );

   always_comb begin
      if (rd_sel_e'(rd_sel_i) == RD_MASK) rd_data_o = mask_w;
      else                                rd_data_o = status_w;
   end

   // R5: a write aimed at the mask address alone leaves the mask untouched
   assert_mask_ro_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_mask_i && !wr_enable_i && !wr_disable_i) |=> $stable(mask_w));
endmodule

// File: tb/intr_gate_ctrl_test.sv
module intr_gate_ctrl_test;
   localparam int W = 16;
   localparam logic [W-1:0] IMPL = 16'h02FF;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [W-1:0] evt_i = '0, wr_data_i = '0;
   logic wr_enable_i = 0, wr_disable_i = 0, wr_clear_i = 0, wr_mask_i = 0, rd_sel_i = 0;
   logic [W-1:0] rd_data_o;
   logic irq_o;

   int n_chk = 0, n_fail = 0;
   logic [W-1:0] exp_m, exp_s;
   logic exp_irq;

   always #5 clk = ~clk;

   intr_gate_ctrl uut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_data_i(wr_data_i),
      .wr_enable_i(wr_enable_i), .wr_disable_i(wr_disable_i),
      .wr_clear_i(wr_clear_i), .wr_mask_i(wr_mask_i),
      .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
   );

   task automatic chk(input string tag);
      rd_sel_i = 1'b0; #1;
      n_chk++;
      if (rd_data_o !== exp_s) begin
         n_fail++;
         $display("FAIL %s status: got %h expected %h", tag, rd_data_o, exp_s);
      end
      rd_sel_i = 1'b1; #1;
      n_chk++;
      if (rd_data_o !== exp_m) begin
         n_fail++;
         $display("FAIL %s mask: got %h expected %h", tag, rd_data_o, exp_m);
      end
      n_chk++;
      if (irq_o !== exp_irq) begin
         n_fail++;
         $display("FAIL %s irq: got %b expected %b", tag, irq_o, exp_irq);
      end
   endtask

   // drive one cycle of stimulus, advance the model, check after the next negedge
   task automatic cyc(input logic en, input logic dis, input logic clr, input logic mw,
                      input logic [W-1:0] wd, input logic [W-1:0] ev, input string tag);
      wr_enable_i = en; wr_disable_i = dis; wr_clear_i = clr; wr_mask_i = mw;
      wr_data_i = wd; evt_i = ev;
      @(posedge clk);
      exp_irq = |(exp_s & ~exp_m);
      if (en)  exp_m = exp_m & ~wd;
      if (dis) exp_m = exp_m | wd;
      exp_m = exp_m & IMPL;
      if (clr) exp_s = exp_s & ~wd;
      exp_s = (exp_s | ev) & IMPL;
      @(negedge clk);
      wr_enable_i = 0; wr_disable_i = 0; wr_clear_i = 0; wr_mask_i = 0;
      wr_data_i = '0; evt_i = '0;
      chk(tag);
   endtask

   initial begin : watchdog
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      logic [15:0] lfsr;
      exp_m = IMPL; exp_s = '0; exp_irq = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #2;
      chk("R1 reset");

      for (int i = 0; i < W; i++) begin
         logic [W-1:0] b;
         b = W'(1) << i;
         cyc(0,0,0,0, '0, b, "R9 event while masked");
         cyc(0,0,0,0, '0, '0, "R7 sticky");
         cyc(0,0,0,1, '0, '0, "R5 mask write zero");
         cyc(1,0,0,0, b, '0, "R3 enable clears");
         cyc(0,0,0,0, '0, '0, "R10 irq after unmask");
         cyc(0,0,1,0, b, b, "R8 event beats clear");
         cyc(0,0,1,0, b, '0, "R8 clear");
         cyc(0,0,0,0, '0, '0, "R10 irq drops");
         cyc(1,1,0,0, b, '0, "R4 disable wins");
         cyc(1,0,0,0, b, '0, "R3 enable again");
         cyc(0,1,0,0, b, '0, "R2 disable sets");
         cyc(0,0,0,1, ~b, b, "R5 mask write ignored");
         cyc(0,0,1,0, '1, '0, "R6 reserved bits / clear all");
      end

      // broad data patterns on each strobe
      cyc(1,0,0,0, 16'hFFFF, '0, "R3 enable all");
      cyc(0,0,0,0, '0, 16'hFFFF, "R6 reserved events ignored");
      cyc(0,0,0,0, '0, '0, "R10 all pending");
      cyc(0,1,0,0, 16'h0155, '0, "R2 partial disable");
      cyc(0,1,0,0, 16'h0000, '0, "R2 zero data no change");
      cyc(1,0,0,0, 16'h0000, '0, "R3 zero data no change");
      cyc(0,0,1,0, 16'h02AA, 16'h0002, "R8 partial clear");
      cyc(0,0,1,0, 16'hFFFF, '0, "R8 clear all");
      cyc(0,0,0,0, '0, '0, "R10 idle");

      lfsr = 16'hACE1;
      for (int k = 0; k < 400; k++) begin
         logic [15:0] r1, r2;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         r1 = lfsr;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         r2 = lfsr & {lfsr[7:0], lfsr[15:8]};
         cyc(r1[0], r1[1], r1[2], r1[3], {r1[11:4], r1[15:8]} ^ r2, r2, "R10 random mix");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule